// File: doc/BRIEF.md
# External DMA channel controller

This block is one DMA channel that serves an external peripheral over three active-low handshake lines. The peripheral pulls its request line low when it wants service. The channel acknowledges each word it moves, and it pulls a done line low alongside the acknowledge of the last word in a block. Software programs a source address, a destination address, a word count and a control word through a small register port. It then waits for the interrupt that marks the end of the block.

The channel has two transfer modes. In fly-by mode, each word needs one bus access. Memory is read (for transmit) or written (for receive) while the acknowledge tells the device to drive or take the data bus itself, so the word never passes through the channel. In copy mode, each word needs two accesses. The first reads the source into a holding register using one chip select. The second writes the holding register to the destination using the other chip select. The acknowledge covers only the access that touches the device. Every access is held until the bus returns ready.

When the request line goes high partway through a block, the channel parks between words. Its addresses and remaining count are kept, and it continues once the request returns.

Top module: `ext_dma_channel`

## Requirements
- R1: Register map, word offsets on `reg_addr`: 0 source address, 1 destination address, 2 word count, 3 control, 4 status. Control bits: bit0 enable, bit1 copy mode, bit2 direction (1 = device to memory, 0 = memory to device), bit3 source increment, bit4 destination increment. Status bit0 is the interrupt flag. Reads return the current values, and unused offsets read 0. After reset every register is 0, `dev_ack_n`, `dev_done_n` and both chip selects are high, `bus_rw_n` is 1, and `bus_addr` and `bus_wdata` are 0 while the channel is idle.
- R2: A word starts only from idle when enable is 1, the count is nonzero and `dev_req_n` is sampled low. The first access cycle is the one after that sampling edge. Enable at 0 produces no bus activity.
- R3: Fly-by mode performs one access per word with `bus_cs_n` = 2'b10. Memory to device reads at the source address (`bus_rw_n` = 1). Device to memory writes at the destination address (`bus_rw_n` = 0). `dev_ack_n` is low for the whole access.
- R4: Each access keeps address, chip selects and direction steady until `bus_ready` is sampled high, and it ends at that edge.
- R5: In copy mode, the read phase has `bus_cs_n` = 2'b10 at the source address. `bus_rdata` is captured when ready is seen. The write phase that follows has `bus_cs_n` = 2'b01, `bus_rw_n` = 0, the destination address and `bus_wdata` equal to the captured word.
- R6: In copy mode, `dev_ack_n` is low only during the device-side phase: the read phase when the direction is device to memory, and the write phase otherwise.
- R7: `dev_done_n` is low exactly when `dev_ack_n` is low and the current word is the last one (count equals 1).
- R8: The count drops by one per finished word. An address used by the mode advances by 4 per word when its increment bit is 1 and otherwise stays fixed. Fly-by moves only the address it uses. Copy mode moves both.
- R9: When the count reaches 0, enable clears and the interrupt flag sets. `irq` follows the flag. Writing 1 to status bit0 clears it, and writing 0 leaves it set.
- R10: If `dev_req_n` is high between words, the channel stays idle with count and addresses unchanged, and it finishes the block once the request returns.
- R11: Setting enable with a count of 0 produces no bus access and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq | output | 1 | Block-complete interrupt, level |
| dev_req_n | input | 1 | Device request, active low |
| dev_ack_n | output | 1 | Device acknowledge, active low |
| dev_done_n | output | 1 | Last-word marker to device, active low |
| bus_addr | output | 28 | Bus byte address |
| bus_wdata | output | 32 | Bus write data (copy-mode write phase) |
| bus_rdata | input | 32 | Bus read data |
| bus_rw_n | output | 1 | 1 = read, 0 = write |
| bus_cs_n | output | 2 | Active-low chip selects: bit0 source/memory, bit1 destination |
| bus_ready | input | 1 | Access completes on a cycle where this is high |

## Verification
The embedded properties check, on every cycle, the following:
- At most one chip select is active.
- An access stalled by ready keeps its address and selects.
- A word starts only after a sampled request.
- The copy-mode write carries the word read in the phase before.
- Done appears only with acknowledge on the last word.
- The count never rises without a register write.
- The flag stays set until it is cleared.
- Enable drops only at completion or on a write.

Only the bench scenarios can show the following:
- Each mode's addresses and count at the end of a block.
- That the acknowledge falls on the device side of the copy for each direction.
- That a request gap leaves the count frozen.
- That a zero count or a cleared enable produces no traffic.

// File: rtl/ext_dma_pkg.sv
package ext_dma_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_SECOND = 2'd2
   } dma_phase_e;

   // packed: enable is bit0, dst_inc is bit4
   typedef struct packed {
      logic dst_inc;
      logic src_inc;
      logic to_mem;
      logic copy_mode;
      logic enable;
   } dma_ctrl_t;

   localparam int unsigned CTRL_W   = 5;
   localparam int unsigned NUM_REGS = 5;
   localparam int unsigned OFS_SRC  = 0;
   localparam int unsigned OFS_DST  = 1;
   localparam int unsigned OFS_CNT  = 2;
   localparam int unsigned OFS_CTRL = 3;
   localparam int unsigned OFS_STAT = 4;

endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
   parameter int AW   = 28,
   parameter int STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   input  logic          inc_en,
   output logic [AW-1:0] addr_q
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= '0;
      else if (load)
         addr_q <= load_val;
      else if (step && inc_en)
         addr_q <= addr_q + STEP_V;
   end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
   import ext_dma_pkg::*;
#(
   parameter int AW  = 28,
   parameter int DW  = 32,
   parameter int CW  = 16,
   parameter int RAW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [RAW-1:0]  addr,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   input  logic [AW-1:0]   src_q,
   input  logic [AW-1:0]   dst_q,
   input  logic            word_done,
   output logic            load_src,
   output logic            load_dst,
   output logic [AW-1:0]   load_val,
   output dma_ctrl_t       ctrl_q,
   output logic [CW-1:0]   cnt_q,
   output logic            irq_q
);
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   logic [NUM_REGS-1:0] hit;
   logic                last_word;
   logic                unused_hi;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
      assign hit[k] = wr && (addr == RAW'(k));
   end

   assign load_src  = hit[OFS_SRC];
   assign load_dst  = hit[OFS_DST];
   assign load_val  = wdata[AW-1:0];
   assign last_word = word_done && (cnt_q == CNT_ONE);
   assign unused_hi = ^wdata[DW-1:AW];

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (hit[OFS_CNT])
         cnt_q <= wdata[CW-1:0];
      else if (word_done)
         cnt_q <= cnt_q - CNT_ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (hit[OFS_CTRL])
         ctrl_q <= dma_ctrl_t'(wdata[CTRL_W-1:0]);
      else if (last_word)
         ctrl_q.enable <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else if (last_word)
         irq_q <= 1'b1;
      else if (hit[OFS_STAT] && wdata[0])
         irq_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (addr == RAW'(OFS_SRC))       rdata = DW'(src_q);
      else if (addr == RAW'(OFS_DST))  rdata = DW'(dst_q);
      else if (addr == RAW'(OFS_CNT))  rdata = DW'(cnt_q);
      else if (addr == RAW'(OFS_CTRL)) rdata = DW'(ctrl_q);
      else if (addr == RAW'(OFS_STAT)) rdata = DW'(irq_q);
   end

   // R8
   cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hit[OFS_CNT]) |-> (cnt_q <= $past(cnt_q)));

   // R9
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_q) && !$past(hit[OFS_STAT] && wdata[0])) |-> irq_q);
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
   import ext_dma_pkg::*;
#(
   parameter int AW = 28,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  dma_ctrl_t     ctrl,
   input  logic [CW-1:0] cnt,
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] dst,
   input  logic          req_n,
   input  logic          bus_ready,
   input  logic [DW-1:0] bus_rdata,
   output logic          ack_n,
   output logic          done_n,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_rw_n,
   output logic [1:0]    bus_cs_n,
   output logic          word_done,
   output logic          step_src,
   output logic          step_dst
);
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   dma_phase_e    state_q, state_d;
   logic [DW-1:0] hold_q;
   logic          start;
   logic          dev_side;

   assign start = (state_q == PH_IDLE) && ctrl.enable && !req_n && (cnt != '0);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PH_IDLE:   if (start) state_d = PH_FIRST;
         PH_FIRST:  if (bus_ready) state_d = ctrl.copy_mode ? PH_SECOND : PH_IDLE;
         PH_SECOND: if (bus_ready) state_d = PH_IDLE;
         default:   state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == PH_FIRST && bus_ready && ctrl.copy_mode)
            hold_q <= bus_rdata;
      end
   end

   assign word_done = bus_ready &&
      ((state_q == PH_FIRST && !ctrl.copy_mode) || state_q == PH_SECOND);
   assign step_src  = word_done && (ctrl.copy_mode || !ctrl.to_mem);
   assign step_dst  = word_done && (ctrl.copy_mode || ctrl.to_mem);

   always_comb begin
      bus_cs_n  = 2'b11;
      bus_rw_n  = 1'b1;
      bus_addr  = '0;
      bus_wdata = '0;
      dev_side  = 1'b0;
      unique case (state_q)
         PH_FIRST: begin
            bus_cs_n = 2'b10;
            bus_rw_n = ctrl.copy_mode || !ctrl.to_mem;
            bus_addr = (ctrl.copy_mode || !ctrl.to_mem) ? src : dst;
            dev_side = !ctrl.copy_mode || ctrl.to_mem;
         end
         PH_SECOND: begin
            bus_cs_n  = 2'b01;
            bus_rw_n  = 1'b0;
            bus_addr  = dst;
            bus_wdata = hold_q;
            dev_side  = !ctrl.to_mem;
         end
         default: ;
      endcase
   end

   assign ack_n  = !dev_side;
   assign done_n = !(dev_side && cnt == CNT_ONE);

   // R3
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n));

   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != PH_IDLE && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_cs_n) && $stable(bus_rw_n)));

   // R2
   start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != PH_IDLE && $past(state_q) == PH_IDLE) |-> $past(!req_n && ctrl.enable));

   // R5
   copy_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_SECOND && $past(state_q) == PH_FIRST) |-> (bus_wdata == $past(bus_rdata)));
endmodule

// File: rtl/ext_dma_channel.sv
module ext_dma_channel
   import ext_dma_pkg::*;
#(
   parameter int AW   = 28,
   parameter int DW   = 32,
   parameter int CW   = 16,
   parameter int RAW  = 3,
   parameter int STEP = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr,
   input  logic [RAW-1:0] reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata,
   output logic           irq,
   input  logic           dev_req_n,
   output logic           dev_ack_n,
   output logic           dev_done_n,
   output logic [AW-1:0]  bus_addr,
   output logic [DW-1:0]  bus_wdata,
   input  logic [DW-1:0]  bus_rdata,
   output logic           bus_rw_n,
   output logic [1:0]     bus_cs_n,
   input  logic           bus_ready
);
   localparam int NPTR = 2;

   if (AW < 8 || AW >= DW) begin : g_bad_aw
      $error("ext_dma_channel: AW must be in [8, DW)");
   end
   if (CW < 2 || CW > AW) begin : g_bad_cw
      $error("ext_dma_channel: CW must be in [2, AW]");
   end
   if ((1 << RAW) < NUM_REGS) begin : g_bad_raw
      $error("ext_dma_channel: RAW too narrow for register map");
   end
   if (STEP < 1 || (STEP & (STEP - 1)) != 0) begin : g_bad_step
      $error("ext_dma_channel: STEP must be a power of two");
   end

   dma_ctrl_t     ctrl_q;
   logic [CW-1:0] cnt_q;
   logic [AW-1:0] load_val;
   logic          word_done;
   logic [NPTR-1:0]         ptr_load, ptr_step, ptr_inc;
   logic [NPTR-1:0][AW-1:0] ptr_q;

   dma_regs #(.AW(AW), .DW(DW), .CW(CW), .RAW(RAW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .src_q     (ptr_q[0]),
      .dst_q     (ptr_q[1]),
      .word_done (word_done),
      .load_src  (ptr_load[0]),
      .load_dst  (ptr_load[1]),
      .load_val  (load_val),
      .ctrl_q    (ctrl_q),
      .cnt_q     (cnt_q),
      .irq_q     (irq)
   );

   assign ptr_inc[0] = ctrl_q.src_inc;
   assign ptr_inc[1] = ctrl_q.dst_inc;

   for (genvar i = 0; i < NPTR; i++) begin : g_ptr
      dma_addr_ctr #(.AW(AW), .STEP(STEP)) u_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (ptr_load[i]),
         .load_val (load_val),
         .step     (ptr_step[i]),
         .inc_en   (ptr_inc[i]),
         .addr_q   (ptr_q[i])
      );
   end

   dma_sequencer #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl_q),
      .cnt       (cnt_q),
      .src       (ptr_q[0]),
      .dst       (ptr_q[1]),
      .req_n     (dev_req_n),
      .bus_ready (bus_ready),
      .bus_rdata (bus_rdata),
      .ack_n     (dev_ack_n),
      .done_n    (dev_done_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rw_n  (bus_rw_n),
      .bus_cs_n  (bus_cs_n),
      .word_done (word_done),
      .step_src  (ptr_step[0]),
      .step_dst  (ptr_step[1])
   );

   // R7
   done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_done_n |-> (cnt_q == CW'(1) && !dev_ack_n));

   // R9
   enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctrl_q.enable) && !$past(reg_wr && reg_addr == RAW'(OFS_CTRL))) |-> irq);
endmodule

// File: tb/tb_ext_dma_channel.sv
module tb_ext_dma_channel;
   localparam int AW = 28;
   localparam int DW = 32;
   localparam int CW = 16;
   localparam logic [31:0] RMIX = 32'hC3C3_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq;
   logic          dev_req_n = 1'b1;
   logic          dev_ack_n, dev_done_n;
   logic [AW-1:0] bus_addr;
   logic [31:0]   bus_wdata, bus_rdata;
   logic          bus_rw_n;
   logic [1:0]    bus_cs_n;
   logic          bus_ready = 1'b1;

   assign bus_rdata = {4'h0, bus_addr} ^ RMIX;

   ext_dma_channel dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .dev_req_n(dev_req_n), .dev_ack_n(dev_ack_n), .dev_done_n(dev_done_n),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rw_n(bus_rw_n), .bus_cs_n(bus_cs_n), .bus_ready(bus_ready)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit cmp_on  = 1'b0;
   bit stall_en = 1'b0;
   logic [7:0] lfsr = 8'h5B;
   int ack_rd = 0, ack_wr = 0, busy = 0, acc_done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int            m_phase;
   logic [AW-1:0] m_src, m_dst;
   logic [CW-1:0] m_cnt;
   logic [4:0]    m_ctrl;
   logic          m_irq;
   logic [31:0]   m_hold;

   always @(posedge clk) begin : model
      bit wd, fin;
      wd = 0; fin = 0;
      if (!rst_n) begin
         m_phase = 0; m_src = '0; m_dst = '0; m_cnt = '0;
         m_ctrl = '0; m_irq = 0; m_hold = '0;
      end else begin
         case (m_phase)
            0: if (m_ctrl[0] && !dev_req_n && m_cnt != 0) m_phase = 1;
            1: if (bus_ready) begin
                  if (m_ctrl[1]) begin
                     m_hold = {4'h0, m_src} ^ RMIX;
                     m_phase = 2;
                  end else begin
                     wd = 1; m_phase = 0;
                  end
               end
            default: if (bus_ready) begin wd = 1; m_phase = 0; end
         endcase
         if (wd) begin
            if ((m_ctrl[1] || !m_ctrl[2]) && m_ctrl[3]) m_src = m_src + 4;
            if ((m_ctrl[1] || m_ctrl[2]) && m_ctrl[4]) m_dst = m_dst + 4;
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin m_ctrl[0] = 0; m_irq = 1; fin = 1; end
         end
         if (reg_wr) begin
            case (reg_addr)
               3'd0: m_src = reg_wdata[AW-1:0];
               3'd1: m_dst = reg_wdata[AW-1:0];
               3'd2: m_cnt = reg_wdata[CW-1:0];
               3'd3: m_ctrl = reg_wdata[4:0];
               3'd4: if (reg_wdata[0] && !fin) m_irq = 0;
               default: ;
            endcase
         end
      end
   end

   // ready pattern
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bus_ready = stall_en ? lfsr[0] : 1'b1;
   end

   // mid-cycle comparison and monitors
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         bit dev;
         logic [1:0]  e_cs;
         logic        e_rw;
         logic [31:0] e_addr, e_wd, e_rd;
         dev = (m_phase == 1 && (!m_ctrl[1] || m_ctrl[2])) || (m_phase == 2 && !m_ctrl[2]);
         e_cs = (m_phase == 1) ? 2'b10 : (m_phase == 2) ? 2'b01 : 2'b11;
         e_rw = !((m_phase == 1 && !m_ctrl[1] && m_ctrl[2]) || m_phase == 2);
         e_addr = (m_phase == 1) ? ((m_ctrl[1] || !m_ctrl[2]) ? {4'h0, m_src} : {4'h0, m_dst})
                : (m_phase == 2) ? {4'h0, m_dst} : 32'h0;
         e_wd = (m_phase == 2) ? m_hold : 32'h0;
         case (reg_addr)
            3'd0: e_rd = {4'h0, m_src};
            3'd1: e_rd = {4'h0, m_dst};
            3'd2: e_rd = {16'h0, m_cnt};
            3'd3: e_rd = {27'h0, m_ctrl};
            3'd4: e_rd = {31'h0, m_irq};
            default: e_rd = 32'h0;
         endcase
         chk("R3 ack", {31'h0, dev_ack_n}, {31'h0, !dev});
         chk("R7 done", {31'h0, dev_done_n}, {31'h0, !(dev && m_cnt == 1)});
         chk("R5 cs", {30'h0, bus_cs_n}, {30'h0, e_cs});
         chk("R3 rw", {31'h0, bus_rw_n}, {31'h0, e_rw});
         chk("R8 addr", {4'h0, bus_addr}, e_addr);
         chk("R5 wdata", bus_wdata, e_wd);
         chk("R9 irq", {31'h0, irq}, {31'h0, m_irq});
         chk("R1 rdata", reg_rdata, e_rd);
      end
      if (!dev_ack_n) begin
         if (bus_cs_n == 2'b10) ack_rd++;
         if (bus_cs_n == 2'b01) ack_wr++;
      end
      if (bus_cs_n != 2'b11) begin
         busy++;
         if (bus_ready) acc_done++;
      end
   end

   task automatic wreg(input int a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input int a, output logic [31:0] d);
      @(posedge clk); #1;
      reg_addr = 3'(a);
      #1 d = reg_rdata;
   endtask

   task automatic wait_irq();
      for (int i = 0; i < 3000 && !irq; i++) @(posedge clk);
      @(posedge clk);
   endtask

   task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
      wreg(0, s); wreg(1, d); wreg(2, c);
   endtask

   task automatic finish_run();
      cmp_on = 1'b0;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired (R2 progress) act=hung exp=done");
      finish_run();
   end

   initial begin : main
      logic [31:0] v, c1, c2;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 reset ack", {31'h0, dev_ack_n}, 32'h1);
      chk("R1 reset done", {31'h0, dev_done_n}, 32'h1);
      chk("R1 reset cs", {30'h0, bus_cs_n}, 32'h3);
      chk("R1 reset irq", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      rreg(3, v); chk("R1 reset ctrl", v, 32'h0);
      cmp_on = 1'b1;

      // R1 readback
      setup(32'h100, 32'h9000, 3);
      rreg(0, v); chk("R1 src readback", v, 32'h100);
      rreg(1, v); chk("R1 dst readback", v, 32'h9000);
      rreg(2, v); chk("R1 cnt readback", v, 32'h3);

      // R3 fly-by transmit, source increments
      dev_req_n = 1'b0;
      wreg(3, 32'h09);
      wait_irq();
      dev_req_n = 1'b1;
      rreg(0, v); chk("R8 flyby tx src", v, 32'h10C);
      rreg(1, v); chk("R8 flyby tx dst untouched", v, 32'h9000);
      rreg(3, v); chk("R9 enable cleared", v, 32'h08);
      rreg(2, v); chk("R8 count zero", v, 32'h0);

      // R9 sticky flag
      wreg(4, 32'h0);
      chk("R9 write0 keeps irq", {31'h0, irq}, 32'h1);
      wreg(4, 32'h1);
      @(negedge clk);
      chk("R9 write1 clears irq", {31'h0, irq}, 32'h0);

      // R4 fly-by receive with stalls, fixed destination
      setup(32'h20, 32'h4000, 4);
      stall_en = 1'b1; acc_done = 0;
      dev_req_n = 1'b0;
      wreg(3, 32'h0D);
      wait_irq();
      dev_req_n = 1'b1;
      chk("R4 one access per word", acc_done, 4);
      rreg(1, v); chk("R8 fixed dst", v, 32'h4000);
      rreg(0, v); chk("R8 unused src fixed", v, 32'h20);
      wreg(4, 1);

      // R6 copy, device to memory
      setup(32'h300, 32'h800, 2);
      ack_rd = 0; ack_wr = 0;
      dev_req_n = 1'b0;
      wreg(3, 32'h1F);
      wait_irq();
      dev_req_n = 1'b1;
      chk("R6 rx no ack on write", ack_wr, 0);
      chk("R6 rx ack on read", {31'h0, ack_rd != 0}, 32'h1);
      rreg(0, v); chk("R8 copy src", v, 32'h308);
      rreg(1, v); chk("R8 copy dst", v, 32'h808);
      wreg(4, 1);

      // R5 copy, memory to device
      setup(32'h500, 32'hA00, 3);
      ack_rd = 0; ack_wr = 0;
      dev_req_n = 1'b0;
      wreg(3, 32'h1B);
      wait_irq();
      dev_req_n = 1'b1;
      stall_en = 1'b0;
      chk("R6 tx no ack on read", ack_rd, 0);
      chk("R6 tx ack on write", {31'h0, ack_wr != 0}, 32'h1);
      rreg(1, v); chk("R5 copy dst advanced", v, 32'hA0C);
      wreg(4, 1);

      // R10 request gap
      setup(32'h1000, 32'h0, 6);
      acc_done = 0;
      dev_req_n = 1'b0;
      wreg(3, 32'h09);
      while (acc_done < 2) @(posedge clk);
      #1 dev_req_n = 1'b1;
      repeat (4) @(posedge clk);
      rreg(2, c1);
      busy = 0;
      repeat (20) @(posedge clk);
      rreg(2, c2);
      chk("R10 count frozen", c2, c1);
      chk("R10 no access in gap", busy, 0);
      chk("R10 partial progress", {31'h0, c1 != 0 && c1 < 6}, 32'h1);
      dev_req_n = 1'b0;
      wait_irq();
      dev_req_n = 1'b1;
      rreg(0, v); chk("R10 resumed to end", v, 32'h1018);
      wreg(4, 1);

      // R11 zero count
      wreg(2, 0);
      busy = 0;
      dev_req_n = 1'b0;
      wreg(3, 32'h09);
      repeat (20) @(posedge clk);
      chk("R11 no access", busy, 0);
      chk("R11 no irq", {31'h0, irq}, 32'h0);

      // R2 enable low blocks
      wreg(2, 3);
      wreg(3, 32'h08);
      busy = 0;
      repeat (20) @(posedge clk);
      chk("R2 disabled no access", busy, 0);
      wreg(3, 32'h09);
      wait_irq();
      dev_req_n = 1'b1;
      chk("R2 enable then runs", {31'h0, irq}, 32'h1);

      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule